// File: doc/BRIEF.md
# Line Interface Status Register

This block is the read-only status byte of an ISDN basic-rate line interface. It shows two live values: the activation state code and the hookswitch level. Beside them it holds four sticky event flags. A flag latches on a particular activation-state transition or on any change of the hookswitch level, and stays set until the host reads the register. The activation state machine and the host bus decode are outside the block. The block sees the state code, the raw hookswitch pin, a one-cycle read strobe and four interrupt enables.

Each sticky flag drives the interrupt line through its own enable. When the interface reaches the fully activated state, a flag latches that can raise an interrupt. The hookswitch pin is asynchronous. It passes through a synchronizer before the block uses its level or detects its edges. Edge detection stays off while the synchronizer refills after reset, so the reset value is never reported as a hookswitch change.

Top module: `line_status_reg`

## Requirements
- R1: rdData[2:0] always equals the current activation state code, with no delay. The codes are F2=000, F3=001, F4=010, F5=011, F6=100, F7=101, F8=110, and bit 0 is the LSB.
- R2: rdData[3] sets one clock edge after the state code changes to F3 (001) from any other code.
- R3: rdData[4] sets one clock edge after the state code enters F7 (101) or leaves F7.
- R4: rdData[5] sets one clock edge after the state code enters F8 (110) or leaves F8.
- R5: rdData[6] shows the hookswitch pin level two clock edges after the pin changes.
- R6: rdData[7] sets three clock edges after any change of the hookswitch pin level.
- R7: A clock edge with rdStrobe high clears rdData[3], rdData[4], rdData[5] and rdData[7]. rdData[2:0] and rdData[6] are not affected.
- R8: A flag whose set event falls on the same clock edge as a clearing read is still set after that edge.
- R9: irq is the OR of rdData[3]&enArriveF3, rdData[4]&enEdgeF7, rdData[5]&enEdgeF8 and rdData[7]&enHookEdge. An enable change shows on irq without delay.
- R10: While reset is asserted, all sticky flags read 0. After reset the register reads 0x00 or 0x40, matching the hookswitch pin, and no hookswitch-change flag appears.
- R11: A state change that enters neither F3, F7 nor F8 and leaves neither F7 nor F8 sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| actState | input | 3 | Activation state code from the state machine |
| hookPin | input | 1 | Raw asynchronous hookswitch level |
| rdStrobe | input | 1 | Host read of the status byte, one cycle |
| enArriveF3 | input | 1 | Interrupt enable for the entry-to-F3 flag |
| enEdgeF7 | input | 1 | Interrupt enable for the F7 transition flag |
| enEdgeF8 | input | 1 | Interrupt enable for the F8 transition flag |
| enHookEdge | input | 1 | Interrupt enable for the hookswitch change flag |
| rdData | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |

## Verification
Each result has its own latency. The state field and the interrupt response to an enable change appear in the same cycle. A state-transition flag appears one edge after the state changes, and a read clears its flags one edge after the strobe. The hookswitch level appears after two edges and its change flag after three. The bench drives every stimulus just after a falling edge. At that moment it queues each expected value tagged with the cycle in which it is due. A monitor compares the queued values shortly after each later falling edge, and it also checks the intermediate cycles in which a value must not have changed yet.

// File: rtl/line_status_pkg.sv
package line_status_pkg;
  localparam int STATE_W = 3;
  localparam int FLAG_N  = 4;

  // flag positions inside the sticky vector
  localparam int FL_F3   = 0;
  localparam int FL_F7   = 1;
  localparam int FL_F8   = 2;
  localparam int FL_HOOK = 3;

  typedef struct packed {
    logic arriveF3;
    logic edgeF7;
    logic edgeF8;
    logic hookEdge;
    logic clearRead;
  } strobes_t;
endpackage

// File: rtl/line_status_ctrl.sv
module line_status_ctrl
  import line_status_pkg::*;
#(
  parameter int STATE_BITS  = STATE_W,
  parameter int SYNC_STAGES = 2,
  parameter logic [STATE_BITS-1:0] CODE_F3 = 3'd1,
  parameter logic [STATE_BITS-1:0] CODE_F7 = 3'd5,
  parameter logic [STATE_BITS-1:0] CODE_F8 = 3'd6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [STATE_BITS-1:0] actState,
  input  logic                  hookPin,
  input  logic                  rdStrobe,
  output strobes_t              strobes,
  output logic                  hookLevel
);
  localparam int WARM   = SYNC_STAGES + 1;
  localparam int WARM_W = $clog2(WARM + 1);

  logic [STATE_BITS-1:0]  prevState;
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   hookPrev;
  logic [WARM_W-1:0]      warmCnt;
  logic                   warmDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevState <= '0;
    else       prevState <= actState;
  end

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= hookPin;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[g] <= 1'b0;
          else       syncChain[g] <= syncChain[g-1];
        end
      end
    end
  endgenerate

  assign hookLevel = syncChain[SYNC_STAGES-1];
  assign warmDone  = (warmCnt == WARM_W'(WARM));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt  <= '0;
      hookPrev <= 1'b0;
    end else begin
      hookPrev <= hookLevel;
      if (!warmDone) warmCnt <= warmCnt + 1'b1;
    end
  end

  logic stateMoved, inF7Now, inF7Was, inF8Now, inF8Was;
  always_comb begin
    stateMoved = (actState != prevState);
    inF7Now    = (actState == CODE_F7);
    inF7Was    = (prevState == CODE_F7);
    inF8Now    = (actState == CODE_F8);
    inF8Was    = (prevState == CODE_F8);
    strobes.arriveF3  = stateMoved && (actState == CODE_F3);
    strobes.edgeF7    = stateMoved && (inF7Now != inF7Was);
    strobes.edgeF8    = stateMoved && (inF8Now != inF8Was);
    strobes.hookEdge  = warmDone && (hookLevel != hookPrev);
    strobes.clearRead = rdStrobe;
  end
endmodule

// File: rtl/line_status_dp.sv
module line_status_dp
  import line_status_pkg::*;
#(
  parameter int STATE_BITS = STATE_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              strobes,
  input  logic [STATE_BITS-1:0] actState,
  input  logic                  hookLevel,
  input  logic [FLAG_N-1:0]     enables,
  output logic [7:0]            rdData,
  output logic                  irq
);
  logic [FLAG_N-1:0] flags;
  logic [FLAG_N-1:0] setVec;
  logic [FLAG_N-1:0] clrVec;

  always_comb begin
    setVec          = '0;
    setVec[FL_F3]   = strobes.arriveF3;
    setVec[FL_F7]   = strobes.edgeF7;
    setVec[FL_F8]   = strobes.edgeF8;
    setVec[FL_HOOK] = strobes.hookEdge;
    clrVec          = {FLAG_N{strobes.clearRead}};
  end

  // set takes precedence over a same-cycle clearing read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~clrVec) | setVec;
  end

  always_comb begin
    rdData      = '0;
    rdData[2:0] = actState[2:0];
    rdData[3]   = flags[FL_F3];
    rdData[4]   = flags[FL_F7];
    rdData[5]   = flags[FL_F8];
    rdData[6]   = hookLevel;
    rdData[7]   = flags[FL_HOOK];
    irq         = |(flags & enables);
  end
endmodule

// File: rtl/line_status_reg.sv
module line_status_reg
  import line_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   actState,
  input  logic         hookPin,
  input  logic         rdStrobe,
  input  logic         enArriveF3,
  input  logic         enEdgeF7,
  input  logic         enEdgeF8,
  input  logic         enHookEdge,
  output logic [7:0]   rdData,
  output logic         irq
);
  strobes_t          strobes;
  logic              hookLevel;
  logic [FLAG_N-1:0] enables;

  always_comb begin
    enables          = '0;
    enables[FL_F3]   = enArriveF3;
    enables[FL_F7]   = enEdgeF7;
    enables[FL_F8]   = enEdgeF8;
    enables[FL_HOOK] = enHookEdge;
  end

  line_status_ctrl #(.STATE_BITS(3), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .actState(actState), .hookPin(hookPin),
    .rdStrobe(rdStrobe), .strobes(strobes), .hookLevel(hookLevel)
  );

  line_status_dp #(.STATE_BITS(3)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .actState(actState),
    .hookLevel(hookLevel), .enables(enables), .rdData(rdData), .irq(irq)
  );
endmodule

// File: rtl/line_status_chk.sv
module line_status_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] actState,
  input logic       hookPin,
  input logic       rdStrobe,
  input logic       enArriveF3,
  input logic       enEdgeF7,
  input logic       enEdgeF8,
  input logic       enHookEdge,
  input logic [7:0] rdData,
  input logic       irq
);
  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              upCnt <= '0;
    else if (upCnt != 2'd2) upCnt <= upCnt + 1'b1;
  end

  // R1
  state_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[2:0] == actState);

  // R2
  arrive_f3_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt != 2'd0 && actState == 3'd1 && $past(actState) != 3'd1) |=> rdData[3]);

  // R3
  edge_f7_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt != 2'd0 && ((actState == 3'd5) != ($past(actState) == 3'd5))) |=> rdData[4]);

  // R4
  edge_f8_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt != 2'd0 && ((actState == 3'd6) != ($past(actState) == 3'd6))) |=> rdData[5]);

  // R5
  hook_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd2) |-> (rdData[6] == $past(hookPin, 2)));

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt != 2'd0 && rdStrobe && actState == $past(actState)) |=> (rdData[5:3] == 3'b000));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq == ((rdData[3] & enArriveF3) | (rdData[4] & enEdgeF7) |
            (rdData[5] & enEdgeF8) | (rdData[7] & enHookEdge)));
endmodule

bind line_status_reg line_status_chk uChk (
  .clk(clk), .rstN(rstN), .actState(actState), .hookPin(hookPin),
  .rdStrobe(rdStrobe), .enArriveF3(enArriveF3), .enEdgeF7(enEdgeF7),
  .enEdgeF8(enEdgeF8), .enHookEdge(enHookEdge), .rdData(rdData), .irq(irq)
);

// File: tb/line_status_reg_test.sv
`timescale 1ns/1ps
module line_status_reg_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] actState;
  logic       hookPin, rdStrobe;
  logic       enArriveF3, enEdgeF7, enEdgeF8, enHookEdge;
  logic [7:0] rdData;
  logic       irq;

  line_status_reg uut (
    .clk(clk), .rstN(rstN), .actState(actState), .hookPin(hookPin),
    .rdStrobe(rdStrobe), .enArriveF3(enArriveF3), .enEdgeF7(enEdgeF7),
    .enEdgeF8(enEdgeF8), .enHookEdge(enHookEdge), .rdData(rdData), .irq(irq)
  );

  always #5 clk = ~clk;

  typedef struct {
    int         due;
    logic       isIrq;
    logic [7:0] mask;
    logic [7:0] val;
    string      tag;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int total = 0;
  int fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expectByte(int k, logic [7:0] mask, logic [7:0] val, string tag);
    item_t it;
    it.due = cyc + k; it.isIrq = 1'b0; it.mask = mask; it.val = val; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic expectIrq(int k, logic v, string tag);
    item_t it;
    it.due = cyc + k; it.isIrq = 1'b1; it.mask = 8'h01; it.val = {7'd0, v}; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares due items shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].due == cyc) begin
          total++;
          if (sb[i].isIrq) begin
            if (irq !== sb[i].val[0]) begin
              fails++;
              $display("FAIL %s: irq actual %b expected %b", sb[i].tag, irq, sb[i].val[0]);
            end
          end else if ((rdData & sb[i].mask) !== (sb[i].val & sb[i].mask)) begin
            fails++;
            $display("FAIL %s: rdData actual %h expected %h (mask %h)",
                     sb[i].tag, rdData, sb[i].val, sb[i].mask);
          end
          sb.delete(i);
        end
      end
    end
  end

  task automatic gap(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostRead();
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: run actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; actState = 3'd0; hookPin = 1'b0; rdStrobe = 1'b0;
    enArriveF3 = 1'b0; enEdgeF7 = 1'b0; enEdgeF8 = 1'b0; enHookEdge = 1'b0;
    @(negedge clk);
    expectByte(0, 8'hFF, 8'h00, "R10 flags clear in reset");
    gap(3);
    rstN = 1'b1;
    expectByte(0, 8'hFF, 8'h00, "R10 reset value pin low");
    expectIrq(0, 1'b0, "R10 no irq after reset");
    expectByte(4, 8'hFF, 8'h00, "R10 no spurious hook flag");
    gap(5);

    enEdgeF7 = 1'b1;
    actState = 3'd1;
    expectByte(0, 8'h07, 8'h01, "R1 state field same cycle");
    expectByte(0, 8'h08, 8'h00, "R2 flag not before edge");
    expectByte(1, 8'hFF, 8'h09, "R2 entry to F3");
    expectIrq(1, 1'b0, "R9 masked F3 flag");
    gap(3);

    actState = 3'd5;
    expectByte(1, 8'hFF, 8'h1D, "R3 entry to F7");
    expectIrq(1, 1'b1, "R9 enabled F7 flag");
    gap(3);

    hostRead();
    expectByte(0, 8'hFF, 8'h05, "R7 read clears flags");
    expectIrq(0, 1'b0, "R7 irq drops after read");
    gap(2);

    actState = 3'd6;
    expectByte(1, 8'hFF, 8'h36, "R4 F7 to F8 sets both");
    gap(3);

    rdStrobe = 1'b1; actState = 3'd5;
    expectByte(1, 8'hFF, 8'h35, "R8 set wins over read");
    @(negedge clk); rdStrobe = 1'b0;
    gap(2);

    hostRead();
    expectByte(0, 8'hFF, 8'h05, "R7 plain read");
    gap(2);

    hookPin = 1'b1;
    expectByte(1, 8'hFF, 8'h05, "R5 level not after one edge");
    expectByte(2, 8'hFF, 8'h45, "R5 level after two edges");
    expectByte(3, 8'hFF, 8'hC5, "R6 hook change flag");
    expectIrq(3, 1'b0, "R9 hook flag masked");
    gap(5);
    enHookEdge = 1'b1;
    expectIrq(0, 1'b1, "R9 enable shows at once");
    gap(2);

    hostRead();
    expectByte(0, 8'hFF, 8'h45, "R7 live bits kept on read");
    gap(2);

    actState = 3'd0;
    expectByte(1, 8'hFF, 8'h50, "R3 leaving F7");
    expectIrq(1, 1'b1, "R9 F7 flag irq");
    gap(3);
    enEdgeF7 = 1'b0;
    expectIrq(0, 1'b0, "R9 disable shows at once");
    gap(2);

    hostRead();
    gap(2);
    actState = 3'd2;
    expectByte(1, 8'hFF, 8'h42, "R11 F2 to F4 no flag");
    gap(3);
    actState = 3'd3;
    expectByte(1, 8'hFF, 8'h43, "R11 F4 to F5 no flag");
    gap(3);

    rstN = 1'b0; actState = 3'd0;
    expectByte(0, 8'hFF, 8'h00, "R10 reset clears flags and level");
    gap(3);
    rstN = 1'b1;
    enArriveF3 = 1'b1; enEdgeF7 = 1'b1; enEdgeF8 = 1'b1; enHookEdge = 1'b1;
    expectByte(1, 8'hFF, 8'h00, "R10 level still syncing");
    expectByte(2, 8'hFF, 8'h40, "R10 reset value pin high");
    expectByte(5, 8'hFF, 8'h40, "R10 no hook flag after reset");
    expectIrq(5, 1'b0, "R10 no irq after reset");
    gap(7);

    while (sb.size() != 0) @(negedge clk);
    gap(1);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule